// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Receiver

This block sits behind a bit sampler on the receive side of a start-stop serial link. Each frame on the line carries one payload word wrapped in two fixed clock bits. The frame opens with a high start bit and closes with a low stop bit, so a low-to-high edge appears at every frame boundary. The payload bits between them may take any value. Bits arrive already recovered, one per cycle in which the bit enable is high.

After reset the receiver looks for that boundary without help from anything else. It tests one candidate alignment at a time. A candidate is kept while the two clock bits hold their fixed values, and it is dropped on the first frame that breaks them. Once eight frames in a row have matched, the receiver declares lock. From then on it delivers each payload word with a one-cycle valid strobe. Lock depends only on the framing bits and on no reference clock. A single bad frame raises an error pulse. Four bad frames in a row drop lock and restart the search.

Top module: `emb_frame_rx`

## Requirements
- R1: While reset is low and in the first cycle after it, `locked`, `word_vld` and `frame_err` are low.
- R2: A frame is PW+2 bits long and is sent in this order: a start bit of 1, then PW payload bits with the most significant bit first, then a stop bit of 0. A bit is taken from `ser_bit` only in a cycle where `bit_en` is 1.
- R3: Starting from reset with the stream aligned on a frame start, `locked` rises in the cycle after the stop bit of the 8th consecutive good frame. It rises from the framing bits alone.
- R4: While searching, the first frame with a wrong start or stop bit abandons the candidate and shifts the alignment by one bit. The receiver therefore locks from any starting bit offset of the stream.
- R5: While locked, each good frame makes `word_vld` pulse for exactly one cycle, in the cycle after its stop bit. At that pulse `word_out` equals the payload that was sent, for any payload pattern. `word_vld` is never high while `locked` is low.
- R6: While locked, one bad frame produces a one-cycle `frame_err` pulse in the cycle after its stop bit, produces no `word_vld`, and leaves `locked` high. A good frame clears the count of consecutive bad frames.
- R7: While locked, the 4th consecutive bad frame drops `locked`, in the same cycle as its `frame_err` pulse, and the search restarts.
- R8: `word_vld`, `frame_err` and `locked` change only in the cycle after a cycle in which `bit_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Sampled serial bit |
| bit_en | input | 1 | ser_bit holds a new bit this cycle |
| word_out | output | PW | Recovered payload word |
| word_vld | output | 1 | One-cycle strobe: word_out is new |
| locked | output | 1 | Frame alignment is locked |
| frame_err | output | 1 | One-cycle pulse: a locked frame had bad clock bits |

## Verification
The assertions check, on every cycle, the following relations:
- `word_vld` only occurs while `locked` is high, and it never lasts two cycles.
- `word_vld` and `frame_err` are never high together.
- Lock is never lost without an error pulse in the same cycle.
- None of the three outputs moves after a cycle in which `bit_en` was low.

Some properties need whole frames of stimulus, so only the bench scenarios can show them:
- the exact frame count to lock;
- relock from an arbitrary bit offset;
- payload integrity against a scoreboard, with idle gaps between bits;
- the difference between three and four consecutive bad frames.

// File: rtl/emb_frame_rx.sv
module emb_frame_rx #(
  parameter int PW        = 18,
  parameter int ACQ_GOOD  = 8,
  parameter int LOSS_BAD  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_bit,
  input  logic          bit_en,
  output logic [PW-1:0] word_out,
  output logic          word_vld,
  output logic          locked,
  output logic          frame_err
);
  localparam int FL = PW + 2;
  localparam int PSW = $clog2(FL);
  localparam int GCW = $clog2(ACQ_GOOD + 1);
  localparam int BCW = $clog2(LOSS_BAD + 1);
  localparam logic [PSW-1:0] LAST = PSW'(FL - 1);

  logic [PSW-1:0] pos;
  logic           skip;
  logic           start_ok;
  logic [PW-1:0]  shreg;
  logic [GCW-1:0] good_cnt;
  logic [BCW-1:0] bad_cnt;

  wire at_stop  = (pos == LAST);
  wire frame_ok = start_ok & ~ser_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      skip      <= 1'b0;
      start_ok  <= 1'b0;
      shreg     <= '0;
      good_cnt  <= '0;
      bad_cnt   <= '0;
      locked    <= 1'b0;
      word_out  <= '0;
      word_vld  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      word_vld  <= 1'b0;
      frame_err <= 1'b0;
      if (bit_en) begin
        if (skip) begin
          skip <= 1'b0;
        end else begin
          pos <= at_stop ? '0 : pos + 1'b1;
          if (pos == '0)
            start_ok <= ser_bit;
          else if (!at_stop)
            shreg <= {shreg[PW-2:0], ser_bit};
          if (at_stop) begin
            if (!locked) begin
              if (frame_ok) begin
                if (good_cnt == GCW'(ACQ_GOOD - 1)) begin
                  locked   <= 1'b1;
                  good_cnt <= '0;
                  bad_cnt  <= '0;
                end else begin
                  good_cnt <= good_cnt + 1'b1;
                end
              end else begin
                good_cnt <= '0;
                skip     <= 1'b1;
              end
            end else if (frame_ok) begin
              bad_cnt  <= '0;
              word_out <= shreg;
              word_vld <= 1'b1;
            end else begin
              frame_err <= 1'b1;
              if (bad_cnt == BCW'(LOSS_BAD - 1)) begin
                locked  <= 1'b0;
                bad_cnt <= '0;
              end else begin
                bad_cnt <= bad_cnt + 1'b1;
              end
            end
          end
        end
      end
    end
  end
endmodule

module emb_frame_rx_chk #(
  parameter int PW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic [PW-1:0] word_out,
  input logic          word_vld,
  input logic          locked,
  input logic          frame_err
);
  assert_vld_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> locked);
  assert_vld_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);
  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_vld && frame_err));
  assert_loss_with_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> frame_err);
  assert_quiet_no_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> (!word_vld && !frame_err && $stable(locked)));
endmodule

bind emb_frame_rx emb_frame_rx_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_out(word_out),
  .word_vld(word_vld), .locked(locked), .frame_err(frame_err));

// File: tb/sim_emb_frame_rx.sv
`timescale 1ns/1ps
module sim_emb_frame_rx;
  localparam int PW = 18;
  logic clk = 1'b0, rst_n = 1'b0, ser_bit = 1'b0, bit_en = 1'b0;
  logic [PW-1:0] word_out;
  logic word_vld, locked, frame_err;
  int checks = 0, errors = 0, err_pulses = 0, vld_seen = 0;
  logic [PW-1:0] q[$];
  logic prev_locked = 1'b0;
  bit gaps = 1'b0;

  always #2.5 clk = ~clk;

  emb_frame_rx #(.PW(PW)) u0 (.clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .bit_en(bit_en),
    .word_out(word_out), .word_vld(word_vld), .locked(locked), .frame_err(frame_err));

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put_bit(logic b);
    if (gaps && ($urandom % 4 == 0)) begin
      bit_en = 1'b0;
      @(negedge clk);
    end
    ser_bit = b;
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic send_frame(logic [PW-1:0] w, bit good);
    if (good) q.push_back(w);
    put_bit(good ? 1'b1 : 1'b0);
    for (int i = PW - 1; i >= 0; i--) put_bit(w[i]);
    put_bit(1'b0);
  endtask

  function automatic logic [PW-1:0] rnd();
    return PW'($urandom);
  endfunction

  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      if (locked && !prev_locked) q.delete();
      if (word_vld) begin
        vld_seen++;
        check("R5 vld while locked", int'(locked), 1);
        if (q.size() == 0) check("R5 unexpected word", 1, 0);
        else check("R5 word match", int'(word_out), int'(q.pop_front()));
      end
      if (frame_err) err_pulses++;
      prev_locked = locked;
    end
  end

  initial begin
    #(5.0 * 150000);
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int e0;
    bit done;
    repeat (3) @(negedge clk);
    check("R1 locked reset", int'(locked), 0);
    check("R1 vld reset", int'(word_vld), 0);
    check("R1 err reset", int'(frame_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 locked after reset", int'(locked), 0);
    // R3: aligned stream locks after exactly 8 good frames
    for (int f = 0; f < 7; f++) send_frame(rnd(), 1'b1);
    check("R3 not locked after 7", int'(locked), 0);
    send_frame(rnd(), 1'b1);
    check("R3 locked after 8", int'(locked), 1);
    check("R8 no err during acq", err_pulses, 0);
    // R2 R5: corner payloads, with idle gaps between bits
    gaps = 1'b1;
    send_frame('0, 1'b1);
    send_frame('1, 1'b1);
    send_frame({(PW/2){2'b01}}, 1'b1);
    send_frame({(PW/2){2'b10}}, 1'b1);
    send_frame(PW'(1), 1'b1);
    for (int f = 0; f < 20; f++) send_frame(rnd(), 1'b1);
    check("R5 queue drained", q.size(), 0);
    // R6: single bad frame
    e0 = err_pulses;
    send_frame(rnd(), 1'b0);
    check("R6 err pulse", err_pulses - e0, 1);
    check("R6 still locked", int'(locked), 1);
    send_frame(rnd(), 1'b1);
    // R6: three bad, good clears, three bad again
    for (int f = 0; f < 3; f++) send_frame(rnd(), 1'b0);
    check("R6 locked after 3 bad", int'(locked), 1);
    send_frame(rnd(), 1'b1);
    for (int f = 0; f < 3; f++) send_frame(rnd(), 1'b0);
    check("R6 count cleared by good", int'(locked), 1);
    send_frame(rnd(), 1'b1);
    check("R6 err count", err_pulses - e0, 7);
    // R7: four consecutive bad frames drop lock
    for (int f = 0; f < 4; f++) send_frame(rnd(), 1'b0);
    check("R7 lock dropped", int'(locked), 0);
    // R4: relock from a shifted bit offset
    for (int b = 0; b < 7; b++) put_bit(b[0]);
    done = 0;
    for (int f = 0; f < 400 && !done; f++) begin
      send_frame(rnd(), 1'b1);
      if (locked) done = 1;
    end
    check("R4 relocked from offset", int'(locked), 1);
    for (int f = 0; f < 15; f++) send_frame(rnd(), 1'b1);
    check("R4 words after relock", q.size(), 0);
    check("R5 word count", vld_seen > 40 ? 1 : 0, 1);
    // R8: idle bit_en leaves outputs quiet
    repeat (20) @(negedge clk);
    check("R8 locked held idle", int'(locked), 1);
    check("R8 no vld idle", int'(word_vld), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule